// File: doc/BRIEF.md
# Quire-to-Posit Rounding Stage

This block takes the signed fixed-point accumulator word of a posit multiply-accumulate datapath and turns it into an 8-bit posit with a two-bit exponent field. The accumulator holds sixteen integer and sixteen fraction bits in two's complement. The conversion is the only place in the datapath where rounding takes place. Two status bits travel with each accumulator word. The first marks that the accumulator has saturated. The second marks that the result is not a real number. Each output carries a zero flag and an infinity flag next to the posit byte.

The converter finds the most significant set bit of the magnitude to get the binary scale. It splits that scale into a regime run and a two-bit exponent. It packs the bits below the leading one as the fraction and rounds the packed string to nearest, ties to even. A negative accumulator gives the two's complement of the positive code.

One word is one beat on a valid/ready input. The rounded code leaves on a valid/ready output through a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle, so the stage sustains one beat per cycle. While the output is stalled, the held result does not change and no new beat is taken.

Top module: `q2p_stream`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A beat accepted on a rising edge (in_valid and in_ready both high) is presented on the output from that edge on, with `out_valid` high. While `out_valid` is high and `out_ready` is low, the output fields hold and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R3: An accumulator word of 0, with both status bits low, yields code 0x00 with the zero flag high and the infinity flag low.
- R4: The not-a-real status bit has top priority. It yields code 0x80 with the infinity flag high and the zero flag low.
- R5: The saturation status bit, with not-a-real low, yields 0x7F when accumulator bit 31 is 0 and 0x81 when it is 1. Both flags are low.
- R6: A positive word of value v = 2^s·(1+f) is encoded from MSB to LSB as follows: a sign bit 0, then the regime, then the two exponent bits s mod 4, then the fraction bits of f. For k = floor(s/4), the regime is k+1 ones followed by a zero when k ≥ 0, and −k zeros followed by a one when k < 0. Examples: 0x00010000 gives 0x40, 0x00018000 gives 0x44, 0x00005000 gives 0x32.
- R7: The seven bits after the sign are the first seven bits of that string. Rounding looks at the next bit (guard) and the OR of all later bits (sticky), and adds one when guard is set and either sticky or the retained LSB is set. So 0x00011000 gives 0x40 and 0x00013000 gives 0x42.
- R8: A negative word yields the 8-bit two's complement of the code for its magnitude. For example, 0xFFFF0000 gives 0xC0 and 0x80000000 gives 0x85.
- R9: A nonzero word with both status bits low never yields 0x00 or 0x80. The smallest magnitude 0x00000001 gives 0x04, and 0xFFFFFFFF gives 0xFC.
- R10: The zero flag is high exactly when the output code is 0x00. The infinity flag is high exactly when the code is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat this cycle |
| in_quire | input | 32 | Signed Q16.16 accumulator word |
| in_overflow | input | 1 | Accumulator saturated; forces signed maximum |
| in_nar | input | 1 | Accumulator is not a real number |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_posit | output | 8 | Rounded posit code, two exponent bits |
| out_zero | output | 1 | Result is zero |
| out_inf | output | 1 | Result is the not-a-real code |

## Verification
A fault in the scale search or in the regime shift puts a code at the wrong binade, several steps away from the expected one. It shows on the first beat whose leading-one position hits the faulty path, one cycle after acceptance. Rounding faults change only the last bit of a code, and only for words whose guard, sticky and retained LSB hit the faulty combination. The sweep walks every leading-one position with patterns that set each of those combinations, for both signs. A handshake fault shows as a changed code, or as a lost or repeated beat, during a stall, in the cycle the stall begins or ends.

// File: rtl/q2p_pkg.sv
`timescale 1ns/1ps
package q2p_pkg;
  localparam int QW_DEF = 32;
  localparam int FW_DEF = 16;
  localparam int POSIT_W = 8;
  localparam int EXP_W = 2;

  typedef struct packed {
    logic [POSIT_W-1:0] code;
    logic               zero;
    logic               inf;
  } q2p_result_t;
endpackage

// File: rtl/q2p_lead_one.sv
`timescale 1ns/1ps
module q2p_lead_one #(
  parameter int W = 32,
  localparam int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [LW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = LW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/q2p_round_pack.sv
`timescale 1ns/1ps
module q2p_round_pack #(
  parameter int PW  = 8,
  parameter int ES  = 2,
  parameter int KW  = 7,
  parameter int FIN = 31,
  localparam int BW = 1 + ES + FIN + PW
) (
  input  logic signed [KW-1:0] regime_k,
  input  logic [ES-1:0]        exp_bits,
  input  logic [FIN-1:0]       frac,
  output logic [PW-2:0]        body
);
  logic          run_bit;
  logic [KW-1:0] run_raw, run;
  logic [BW-1:0] base, shifted, fill, packed_str;
  logic [PW-2:0] trunc;
  logic          guard, sticky, inc;
  logic [PW-1:0] sum;

  assign run_bit = ~regime_k[KW-1];
  assign run_raw = run_bit ? ($unsigned(regime_k) + 1'b1) : $unsigned(-regime_k);
  assign run     = (run_raw > KW'(PW-1)) ? KW'(PW-1) : run_raw;

  assign base       = {~run_bit, exp_bits, frac, {PW{1'b0}}};
  assign shifted    = base >> run;
  assign fill       = run_bit ? ~({BW{1'b1}} >> run) : '0;
  assign packed_str = shifted | fill;

  assign trunc  = packed_str[BW-1 -: PW-1];
  assign guard  = packed_str[BW-PW];
  assign sticky = |packed_str[BW-PW-1:0];
  assign inc    = guard & (sticky | trunc[0]);
  assign sum    = {1'b0, trunc} + PW'(inc);

  always_comb begin
    if (sum[PW-1])
      body = '1;
    else if (sum[PW-2:0] == '0)
      body = (PW-1)'(1);
    else
      body = sum[PW-2:0];
  end
endmodule

// File: rtl/q2p_convert.sv
`timescale 1ns/1ps
module q2p_convert #(
  parameter int QW = 32,
  parameter int FW = 16,
  parameter int PW = 8,
  parameter int ES = 2,
  localparam int LW  = $clog2(QW),
  localparam int SCW = LW + 2
) (
  input  logic [QW-1:0] quire,
  input  logic          sat,
  input  logic          nar,
  output logic [PW-1:0] code,
  output logic          zero,
  output logic          inf
);
  logic                  neg, found;
  logic [QW-1:0]         mag;
  logic [LW-1:0]         lead_pos, shamt;
  logic [QW-2:0]         frac;
  logic signed [SCW-1:0] scale, regime_k;
  logic [ES-1:0]         exp_bits;
  logic [PW-2:0]         body;
  logic [PW-1:0]         mag_code, signed_code;

  assign neg = quire[QW-1];
  assign mag = neg ? (~quire + 1'b1) : quire;

  q2p_lead_one #(.W(QW)) u_lead (
    .vec   (mag),
    .pos   (lead_pos),
    .found (found)
  );

  assign shamt    = LW'(QW-1) - lead_pos;
  assign frac     = (QW-1)'(mag << shamt);
  assign scale    = $signed({2'b00, lead_pos}) - $signed(SCW'(FW));
  assign regime_k = scale >>> ES;
  assign exp_bits = scale[ES-1:0];

  q2p_round_pack #(.PW(PW), .ES(ES), .KW(SCW), .FIN(QW-1)) u_pack (
    .regime_k (regime_k),
    .exp_bits (exp_bits),
    .frac     (frac),
    .body     (body)
  );

  assign mag_code    = {1'b0, body};
  assign signed_code = neg ? (~mag_code + 1'b1) : mag_code;

  always_comb begin
    if (nar)
      code = {1'b1, {(PW-1){1'b0}}};
    else if (sat)
      code = neg ? {1'b1, {(PW-2){1'b0}}, 1'b1} : {1'b0, {(PW-1){1'b1}}};
    else if (!found)
      code = '0;
    else
      code = signed_code;
  end

  assign zero = !nar && !sat && !found;
  assign inf  = nar;
endmodule

// File: rtl/q2p_stream.sv
`timescale 1ns/1ps
module q2p_stream
  import q2p_pkg::*;
#(
  parameter int QUIRE_W = QW_DEF,
  parameter int FRAC_W  = FW_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [QUIRE_W-1:0] in_quire,
  input  logic               in_overflow,
  input  logic               in_nar,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [POSIT_W-1:0] out_posit,
  output logic               out_zero,
  output logic               out_inf
);
  q2p_result_t res_d, res_q;
  logic        valid_q;
  logic        take;

  q2p_convert #(.QW(QUIRE_W), .FW(FRAC_W), .PW(POSIT_W), .ES(EXP_W)) u_conv (
    .quire (in_quire),
    .sat   (in_overflow),
    .nar   (in_nar),
    .code  (res_d.code),
    .zero  (res_d.zero),
    .inf   (res_d.inf)
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        res_q   <= res_d;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_posit = res_q.code;
  assign out_zero  = res_q.zero;
  assign out_inf   = res_q.inf;
endmodule

// File: rtl/q2p_stream_chk.sv
`timescale 1ns/1ps
module q2p_stream_chk #(
  parameter int QW = 32,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [QW-1:0] in_quire,
  input logic          in_overflow,
  input logic          in_nar,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_posit,
  input logic          out_zero,
  input logic          out_inf
);
  localparam logic [PW-1:0] NAR_CODE = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] MAXP     = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] NMAXP    = {1'b1, {(PW-2){1'b0}}, 1'b1};

  logic acc;
  assign acc = in_valid && in_ready;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_posit) && $stable(out_zero) && $stable(out_inf)));

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_nar && !in_overflow && in_quire == '0) |=> (out_posit == '0 && out_zero && !out_inf));

  assert_nar_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_nar) |=> (out_posit == NAR_CODE && out_inf && !out_zero));

  assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_nar && in_overflow) |=> (out_posit == ($past(in_quire[QW-1]) ? NMAXP : MAXP)));

  assert_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_nar && !in_overflow && in_quire[QW-1]) |=> out_posit[PW-1]);

  assert_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_nar && in_quire != '0) |=> (out_posit != '0 && out_posit != NAR_CODE));

  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_zero && out_inf));
endmodule

bind q2p_stream q2p_stream_chk #(.QW(QUIRE_W), .PW(q2p_pkg::POSIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_quire    (in_quire),
  .in_overflow (in_overflow),
  .in_nar      (in_nar),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_posit   (out_posit),
  .out_zero    (out_zero),
  .out_inf     (out_inf)
);

// File: tb/tb_q2p_stream.sv
`timescale 1ns/1ps
module tb_q2p_stream;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_quire = '0;
  logic        in_overflow = 1'b0;
  logic        in_nar = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_posit;
  logic        out_zero;
  logic        out_inf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       pend = 1'b0;
  logic [7:0] exp_code;
  string      exp_tag;

  always #2 clk = ~clk;

  q2p_stream dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_quire(in_quire), .in_overflow(in_overflow), .in_nar(in_nar),
    .out_valid(out_valid), .out_ready(out_ready), .out_posit(out_posit),
    .out_zero(out_zero), .out_inf(out_inf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // Reference: build the posit bit string MSB first, then round.
  function automatic logic [7:0] ref_posit(logic [31:0] q, logic ovf, logic nar);
    longint m;
    int p, s, k, e, n, body;
    bit [79:0] str;
    bit g, st;
    logic neg;
    if (nar) return 8'h80;
    if (ovf) return q[31] ? 8'h81 : 8'h7F;
    if (q == 0) return 8'h00;
    neg = q[31];
    m = longint'($signed(q));
    if (m < 0) m = -m;
    p = 0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    s = p - 16;
    e = ((s % 4) + 4) % 4;
    k = (s - e) / 4;
    str = '0;
    n = 0;
    if (k >= 0) begin
      for (int i = 0; i <= k; i++) begin str[79-n] = 1'b1; n++; end
      n++;
    end else begin
      n = n - k;
      str[79-n] = 1'b1;
      n++;
    end
    str[79-n] = e[1]; n++;
    str[79-n] = e[0]; n++;
    for (int i = p - 1; i >= 0; i--) begin str[79-n] = m[i]; n++; end
    body = 0;
    for (int i = 0; i < 7; i++) body = body * 2 + int'(str[79-i]);
    g  = str[72];
    st = |str[71:0];
    if (g && (st || body[0])) body++;
    if (body > 127) body = 127;
    if (body == 0) body = 1;
    return neg ? 8'(-body) : 8'(body);
  endfunction

  task automatic check_out();
    chk({exp_tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    chk(exp_tag, {24'd0, out_posit}, {24'd0, exp_code});
    chk("R10 zero flag", {31'd0, out_zero}, {31'd0, exp_code == 8'h00});
    chk("R10 inf flag", {31'd0, out_inf}, {31'd0, exp_code == 8'h80});
  endtask

  task automatic beat(logic [31:0] q, logic ovf, logic nar, logic [7:0] hand, bit use_hand, string tag);
    @(negedge clk);
    if (pend) check_out();
    in_quire    = q;
    in_overflow = ovf;
    in_nar      = nar;
    in_valid    = 1'b1;
    exp_code    = ref_posit(q, ovf, nar);
    exp_tag     = tag;
    if (use_hand) chk({tag, " reference"}, {24'd0, exp_code}, {24'd0, hand});
    pend = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk);
    if (pend) check_out();
    in_valid = 1'b0;
    pend = 1'b0;
    @(negedge clk);
    chk("R2 empty after drain", {31'd0, out_valid}, 32'd0);
  endtask

  function automatic logic [31:0] xs(logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic string tag_of(logic [31:0] q, logic ovf, logic nar);
    if (nar) return "R4";
    if (ovf) return "R5";
    if (q == 0) return "R3";
    if (q[31]) return "R8";
    return "R7";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, q, hold_code;
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // Directed values with hand-derived codes
    beat(32'h0001_0000, 0, 0, 8'h40, 1, "R6 one");
    beat(32'h0001_8000, 0, 0, 8'h44, 1, "R6 one-and-half");
    beat(32'h0000_5000, 0, 0, 8'h32, 1, "R6 0.3125");
    beat(32'h0001_1000, 0, 0, 8'h40, 1, "R7 tie down to even");
    beat(32'h0001_3000, 0, 0, 8'h42, 1, "R7 tie up to even");
    beat(32'h7FFF_FFFF, 0, 0, 8'h7B, 1, "R7 largest positive");
    beat(32'hFFFF_0000, 0, 0, 8'hC0, 1, "R8 minus one");
    beat(32'h8000_0000, 0, 0, 8'h85, 1, "R8 most negative");
    beat(32'h0000_0001, 0, 0, 8'h04, 1, "R9 smallest positive");
    beat(32'hFFFF_FFFF, 0, 0, 8'hFC, 1, "R9 smallest negative");
    beat(32'h0000_0000, 0, 0, 8'h00, 1, "R3 zero");
    beat(32'h1234_5678, 0, 1, 8'h80, 1, "R4 nar");
    beat(32'h0000_0000, 1, 1, 8'h80, 1, "R4 nar over saturation");
    beat(32'h0000_0000, 1, 0, 8'h7F, 1, "R5 sat positive");
    beat(32'h8000_0000, 1, 0, 8'h81, 1, "R5 sat negative");
    drain();

    // Sweep every leading-one position with structured and random tails
    seed = 32'h1ACE_B00C;
    for (int p = 0; p < 32; p++) begin
      for (int pat = 0; pat < 24; pat++) begin
        logic [31:0] low, mask;
        mask = (32'd1 << p) - 32'd1;
        seed = xs(seed);
        case (pat)
          0: low = '0;
          1: low = '1;
          2: low = 32'd1 << (p > 0 ? p - 1 : 0);
          3: low = (32'd1 << (p > 0 ? p - 1 : 0)) | 32'd1;
          4: low = 32'hAAAA_AAAA;
          5: low = 32'h5555_5555;
          default: low = seed;
        endcase
        q = (32'd1 << p) | (low & mask);
        beat(q, 0, 0, 8'h00, 0, tag_of(q, 0, 0));
        q = ~q + 32'd1;
        beat(q, 0, 0, 8'h00, 0, tag_of(q, 0, 0));
      end
    end
    drain();

    // Random words with occasional status bits
    for (int i = 0; i < 4000; i++) begin
      logic o, n;
      seed = xs(seed);
      q = xs(seed ^ 32'h9E37_79B9);
      o = (seed[2:0] == 3'd0);
      n = (seed[6:3] == 4'd0);
      if (seed[10:8] == 3'd0) q = q >> seed[15:11];
      beat(q, o, n, 8'h00, 0, tag_of(q, o, n));
    end
    drain();

    // Back-pressure: stall with a second beat waiting
    @(negedge clk);
    out_ready   = 1'b0;
    in_quire    = 32'h0001_8000;
    in_overflow = 1'b0;
    in_nar      = 1'b0;
    in_valid    = 1'b1;
    @(negedge clk);
    in_quire = 32'hFFFF_0000;
    hold_code = {24'd0, out_posit};
    chk("R2 first beat presented", {31'd0, out_valid}, 32'd1);
    chk("R2 first beat code", hold_code, 32'h44);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
      chk("R2 held code while stalled", {24'd0, out_posit}, hold_code);
    end
    out_ready = 1'b1;
    #0;
    chk("R2 in_ready follows out_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second beat after stall", {24'd0, out_posit}, 32'hC0);
    chk("R2 second beat valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R2 drained after stall", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule